// File: doc/BRIEF.md
# Serial Command Port with Interrupt Status for a Message Record/Playback Engine

This block is the slave side of a four-wire serial port that controls a message record and playback engine. A host lowers an active-low select and clocks in a 16-bit command, least significant bit first: an 11-bit message address, then 5 control bits. On the same clocks the block shifts out a 16-bit status word. That word holds the pending interrupt flags and the engine's current row address, so one transfer can both read the status and start the next operation.

A decoded command acts only after select goes high again, and only if exactly 16 serial clocks were received. The engine raises an active-low interrupt when an operation ends at an end-of-message mark or at address overflow. The next falling edge of select clears that interrupt. The serial clock, select and data lines are synchronized into the system clock domain, and all edge detection and shifting happen there. A small address-counter stub stands in for the storage engine: while running it advances its row address once every `TICK_DIV` system cycles.

Top module: `spicmd_top`

## Requirements
- R1: Serial data is sampled on rising serial-clock edges, least significant bit first. Command bits 10:0 are the message address and bits 15:11 the control field. A command has no effect before select rises: `busy` does not change while select is low.
- R2: Control field, counted from command bit 11: run (bit 11), play (bit 12, 1 = playback, 0 = record), use-address (bit 13), power-up (bit 14), reserved (bit 15, ignored). An operation starts only when run and power-up are both set. `play_mode` follows bit 12 of every accepted command.
- R3: When an operation starts with use-address set, the row address loads from command bits 10:0. With use-address clear, it keeps its current value.
- R4: An accepted command with run or power-up clear stops a running operation without raising an interrupt. The row address does not change while idle.
- R5: The status word is captured at the falling edge of select: bit 0 overflow flag, bit 1 end-of-message flag, bits 4:2 zero, bits 15:5 row address. It is driven on `miso` least significant bit first, advancing on falling serial-clock edges. `miso` is 0 after reset.
- R6: While running, the row address increments every `TICK_DIV` system cycles. A step taken at address 2047 instead ends the operation and sets the overflow flag.
- R7: A pulse on `eom_hit` while running ends the operation and sets the end-of-message flag. While idle the pulse is ignored.
- R8: `int_n` is low while either flag is set. The flags clear at the next falling edge of select, and the status captured at that edge still shows them.
- R9: A transfer of other than 16 serial clocks is discarded and the run state is unchanged. Its falling edge of select still clears the interrupt.
- R10: After reset `int_n` is 1, `busy`, `play_mode` and `miso` are 0, and the status word reads 0.
- R11: One transfer can read a pending interrupt status and start a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idle low |
| ss_n | input | 1 | Active-low select framing each transfer |
| mosi | input | 1 | Serial command data in |
| eom_hit | input | 1 | End-of-message mark from storage, pulse |
| miso | output | 1 | Serial status data out |
| int_n | output | 1 | Active-low interrupt, end-of-message or overflow |
| busy | output | 1 | Engine operation in progress |
| play_mode | output | 1 | 1 = playback, 0 = record, from last accepted command |

## Verification
The bench counts 8- and 17-clock transfers against a running engine and against a pending interrupt. A design that counts loosely would start or stop operations, and a design that clears only on accepted commands would leave `int_n` low. It reads status in the transfer right after an end-of-message and after overflow at address 2047. A design that clears the flags before capturing them would return zeros there, and one that wraps the address would report 0 with no overflow. It also sends commands whose power-up bit is clear and commands without use-address. A design that ignores power-up would start, and one that always loads the address would lose the running row.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int ADDR_W = 11;
  localparam int CTRL_W = 5;
  localparam int WORD_W = ADDR_W + CTRL_W;
  localparam int KEEP_W = WORD_W - 1;   // reserved top bit is dropped
  localparam int FLAG_W = 5;            // status bits below the address

  typedef struct packed {
    logic pwr;
    logic use_addr;
    logic play;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spicmd_shift.sv
module spicmd_shift
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_lvl,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_lvl,
  input  logic [WORD_W-1:0] status_in,
  output logic              miso,
  output logic              cmd_valid,
  output logic [KEEP_W-1:0] cmd_word
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (ss_fall) begin
        tx_q  <= status_in;
        cnt_q <= '0;
      end else if (!ss_lvl) begin
        if (sclk_rise) begin
          rx_q <= {mosi_lvl, rx_q[WORD_W-1:1]};
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) tx_q <= {1'b0, tx_q[WORD_W-1:1]};
      end
      if (ss_rise && cnt_q == CNT_FULL) begin
        cmd_valid <= 1'b1;
        cmd_word  <= rx_q[KEEP_W-1:0];
      end
    end
  end

  assign miso = tx_q[0];
endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine
  import spicmd_pkg::*;
#(
  parameter int TICK_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [KEEP_W-1:0] cmd_word,
  input  logic              ss_fall,
  input  logic              eom_hit,
  output logic              busy,
  output logic              play_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              ovf_flag,
  output logic              eom_flag
);
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  ctrl_t             ctl;
  logic [ADDR_W-1:0] cmd_addr;
  logic [TICK_W-1:0] tick_q;

  assign ctl      = ctrl_t'(cmd_word[KEEP_W-1:ADDR_W]);
  assign cmd_addr = cmd_word[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      play_mode <= 1'b0;
      cur_addr  <= '0;
      ovf_flag  <= 1'b0;
      eom_flag  <= 1'b0;
      tick_q    <= '0;
    end else begin
      if (ss_fall) begin
        ovf_flag <= 1'b0;
        eom_flag <= 1'b0;
      end
      if (cmd_valid) begin
        play_mode <= ctl.play;
        tick_q    <= '0;
        if (ctl.run && ctl.pwr) begin
          busy <= 1'b1;
          if (ctl.use_addr) cur_addr <= cmd_addr;
        end else begin
          busy <= 1'b0;
        end
      end else if (busy) begin
        if (eom_hit) begin
          busy     <= 1'b0;
          eom_flag <= 1'b1;
        end else if (tick_q == TICK_LAST) begin
          tick_q <= '0;
          if (cur_addr == ADDR_LAST) begin
            busy     <= 1'b0;
            ovf_flag <= 1'b1;
          end else begin
            cur_addr <= cur_addr + 1'b1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spicmd_top.sv
module spicmd_top
  import spicmd_pkg::*;
#(
  parameter int TICK_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  input  logic eom_hit,
  output logic miso,
  output logic int_n,
  output logic busy,
  output logic play_mode
);
  logic [2:0]        pins_s;
  logic              sclk_lvl, ss_lvl, mosi_lvl;
  logic              sclk_prev, ss_prev;
  logic              sclk_rise, sclk_fall, ss_rise, ss_fall;
  logic              cmd_valid;
  logic [KEEP_W-1:0] cmd_word;
  logic [ADDR_W-1:0] cur_addr;
  logic              ovf_flag, eom_flag;
  logic [WORD_W-1:0] status_word;

  spicmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({mosi, ss_n, sclk}), .q(pins_s)
  );
  assign {mosi_lvl, ss_lvl, sclk_lvl} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      ss_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_lvl;
      ss_prev   <= ss_lvl;
    end
  end

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign ss_rise   = ss_lvl & ~ss_prev;
  assign ss_fall   = ~ss_lvl & ss_prev;

  assign status_word = {cur_addr, {(FLAG_W-2){1'b0}}, eom_flag, ovf_flag};

  spicmd_shift u_shift (
    .clk(clk), .rst(rst), .ss_lvl(ss_lvl), .ss_fall(ss_fall), .ss_rise(ss_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_lvl(mosi_lvl),
    .status_in(status_word), .miso(miso), .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  spicmd_engine #(.TICK_DIV(TICK_DIV)) u_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ss_fall(ss_fall), .eom_hit(eom_hit), .busy(busy), .play_mode(play_mode),
    .cur_addr(cur_addr), .ovf_flag(ovf_flag), .eom_flag(eom_flag)
  );

  assign int_n = ~(ovf_flag | eom_flag);
endmodule

// File: rtl/spicmd_chk.sv
module spicmd_chk
  import spicmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ss_fall,
  input logic              sclk_fall,
  input logic              cmd_valid,
  input logic              busy,
  input logic              int_n,
  input logic              miso,
  input logic [ADDR_W-1:0] cur_addr
);
  // R8
  int_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ss_fall && !busy |=> int_n);

  // R7
  int_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> !busy && $past(busy));

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  // R5
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sclk_fall) && !$past(ss_fall) |-> $stable(miso));

  // R4
  addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) && !$past(cmd_valid) |-> $stable(cur_addr));
endmodule

bind spicmd_top spicmd_chk u_chk (
  .clk(clk), .rst(rst), .ss_fall(ss_fall), .sclk_fall(sclk_fall),
  .cmd_valid(cmd_valid), .busy(busy), .int_n(int_n), .miso(miso),
  .cur_addr(cur_addr)
);

// File: tb/sim_spicmd_top.sv
module sim_spicmd_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int TICK = 256;
  localparam logic [15:0] RUN = 16'h0800, PLAY = 16'h1000, USEA = 16'h2000,
                          PWR = 16'h4000, RSV = 16'h8000;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0, eom_hit = 1'b0;
  logic miso, int_n, busy, play_mode;
  int n_run = 0, n_fail = 0;
  logic busy_pre, int_mid;
  logic [15:0] rd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spicmd_top #(.TICK_DIV(TICK)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .eom_hit(eom_hit),
    .miso(miso), .int_n(int_n), .busy(busy), .play_mode(play_mode)
  );

  // {command, busy after, play after, address in next status}
  localparam logic [28:0] VEC [6] = '{
    {RUN|PLAY|USEA|PWR | 16'd100,  1'b1, 1'b1, 11'd100},
    {PWR | 16'd555,                1'b0, 1'b0, 11'd100},
    {RUN|PWR | 16'd300,            1'b1, 1'b0, 11'd100},
    {RSV|RUN|USEA|PWR | 16'd2000,  1'b1, 1'b0, 11'd2000},
    {RUN|USEA | 16'd7,             1'b0, 1'b0, 11'd2000},
    {RUN|PLAY|USEA|PWR | 16'd0,    1'b1, 1'b1, 11'd0}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] sts);
    sts = '0;
    ss_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[i % 16];
      waitc(HALF);
      if (i < 16) sts[i] = miso;
      if (i == 0) int_mid = int_n;
      sclk = 1'b1;
      waitc(HALF);
      sclk = 1'b0;
    end
    waitc(HALF);
    busy_pre = busy;
    ss_n = 1'b1;
    waitc(2 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] prev_addr;
    waitc(5);
    rst = 1'b0;
    waitc(3);
    // R10 reset state
    check("R10 int_n", {15'd0, int_n}, 16'd1);
    check("R10 busy", {15'd0, busy}, 16'd0);
    check("R10 miso", {15'd0, miso}, 16'd0);
    check("R10 play", {15'd0, play_mode}, 16'd0);

    // R1 R2 R3 R4 R10: table walk; each transfer returns the previous status
    prev_addr = '0;
    for (int i = 0; i < 6; i++) begin
      xfer(VEC[i][28:13], 16, rd);
      check("R5 R3 status", rd, {prev_addr, 5'd0});
      check("R2 busy", {15'd0, busy}, {15'd0, VEC[i][12]});
      check("R2 play", {15'd0, play_mode}, {15'd0, VEC[i][11]});
      if (i == 0) check("R1 busy before select rise", {15'd0, busy_pre}, 16'd0);
      prev_addr = VEC[i][10:0];
    end
    xfer(PWR, 16, rd);
    check("R3 status final", rd, 16'h0000);
    check("R4 stop", {15'd0, busy}, 16'd0);
    check("R4 no int on stop", {15'd0, int_n}, 16'd1);

    // R6 overflow at top address
    xfer(RUN|USEA|PWR | 16'd2046, 16, rd);
    waitc(2 * TICK + 20);
    check("R6 int_n", {15'd0, int_n}, 16'd0);
    check("R6 busy", {15'd0, busy}, 16'd0);
    xfer(PWR, 16, rd);
    check("R6 R8 status", rd, 16'hFFE1);
    check("R8 cleared at select fall", {15'd0, int_mid}, 16'd1);
    xfer(PWR, 16, rd);
    check("R8 flags gone", rd, 16'hFFE0);

    // R7 end-of-message, then R11 read and start in one transfer
    xfer(RUN|USEA|PWR | 16'd50, 16, rd);
    waitc(20);
    eom_hit = 1'b1; waitc(1); eom_hit = 1'b0; waitc(2);
    check("R7 int_n", {15'd0, int_n}, 16'd0);
    check("R7 busy", {15'd0, busy}, 16'd0);
    xfer(RUN|USEA|PWR | 16'd9, 16, rd);
    check("R11 status read", rd, 16'h0642);
    check("R11 started", {15'd0, busy}, 16'd1);
    check("R11 int cleared", {15'd0, int_n}, 16'd1);
    xfer(PWR, 16, rd);
    check("R11 new address", rd, 16'h0120);

    // R7 ignored while idle
    eom_hit = 1'b1; waitc(1); eom_hit = 1'b0; waitc(3);
    check("R7 idle ignored", {15'd0, int_n}, 16'd1);

    // R9 short and long transfers
    xfer(RUN|USEA|PWR | 16'd30, 16, rd);
    xfer(PWR, 8, rd);
    check("R9 short keeps run", {15'd0, busy}, 16'd1);
    eom_hit = 1'b1; waitc(1); eom_hit = 1'b0; waitc(2);
    check("R9 int set", {15'd0, int_n}, 16'd0);
    xfer(RUN|USEA|PWR | 16'd5, 8, rd);
    check("R9 short clears int", {15'd0, int_n}, 16'd1);
    check("R9 short no start", {15'd0, busy}, 16'd0);
    xfer(RUN|USEA|PWR | 16'd5, 17, rd);
    check("R9 long no start", {15'd0, busy}, 16'd0);
    xfer(PWR, 16, rd);
    check("R9 status after discards", rd, 16'h03C0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule